// File: doc/BRIEF.md
# Failed Sector Capture Register

This block belongs to one channel of a signature-checking engine. In automatic mode it records the number of the first sector whose signature check failed. It then holds that number until the processor has dealt with it. The processor must read the captured value and clear the fail flag, in either order. Only when both have happened does the block accept a new capture.

A further failure that arrives while the register is held does not overwrite the stored number. It produces a one-cycle overrun pulse instead. A read made while the debug suspend input is high does not count toward the release, so a debugger can look at the register without changing it.

In semi-automatic mode the register instead records the sector of the latest compression completion, and the hold logic plays no part. In processor-driven mode every strobe is ignored. A synchronous software reset clears the whole state.

Top module: `fail_sector_capture`

## Requirements
- R1: After rst_n is asserted, sector_q is 0 and fail_flag, frozen and overrun are all low.
- R2: In automatic mode (mode = 2'b00), a fail_stb while frozen is low loads sector_in into sector_q and sets fail_flag and frozen at the next clock edge.
- R3: While frozen is high, a fail_stb leaves sector_q unchanged and keeps fail_flag high. It pulses overrun high for exactly one cycle and discards any read or clear already recorded.
- R4: frozen stays high until both of the following have been recorded in either order: an rd_stb while suspend is low, and a clr_stb that cleared fail_flag. frozen falls at the clock edge after the edge that recorded the later of the two.
- R5: An rd_stb that arrives while suspend is high is not recorded and does not count toward release.
- R6: A clr_stb in automatic mode while fail_flag is high clears fail_flag at the next edge, unless fail_stb is high in the same cycle. In that case the failure takes precedence and fail_flag remains high.
- R7: In semi-automatic mode (mode = 2'b01), done_stb loads sector_in into sector_q. fail_stb, rd_stb and clr_stb have no effect on sector_q, fail_flag or frozen in this mode.
- R8: In processor-driven mode (mode = 2'b10 or 2'b11), sector_q, fail_flag, frozen and overrun do not change for any strobe.
- R9: sw_rst clears sector_q to 0 and drops fail_flag and frozen at the next edge, taking priority over every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| mode | input | 2 | 00 automatic, 01 semi-automatic, 1x processor-driven |
| sector_in | input | SECTOR_W | Number of the sector currently being processed |
| fail_stb | input | 1 | Single-cycle signature failure strobe |
| done_stb | input | 1 | Single-cycle compression-complete strobe |
| rd_stb | input | 1 | Single-cycle processor read of the captured value |
| clr_stb | input | 1 | Single-cycle processor clear of the fail flag |
| suspend | input | 1 | Debug suspend level |
| sector_q | output | SECTOR_W | Captured sector number |
| fail_flag | output | 1 | Fail status flag |
| overrun | output | 1 | One-cycle overrun pulse |
| frozen | output | 1 | High while the captured value is held |

## Verification
Every output is a register. A capture, flag clear, overrun pulse or software reset therefore shows at the first edge after its strobe. The release of frozen needs one more edge after the last of the read and clear has been recorded. The bench drives its strobes on the falling edge and holds them for exactly one cycle. It samples on the following falling edge, which is one edge after the strobe. For the release and for the end of the overrun pulse it waits one further falling edge before checking. It also checks the cycle just before the release, to prove that frozen does not fall early.

// File: rtl/fail_sector_capture.sv
module fail_sector_capture #(
  parameter int SECTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_rst,
  input  logic [1:0]          mode,
  input  logic [SECTOR_W-1:0] sector_in,
  input  logic                fail_stb,
  input  logic                done_stb,
  input  logic                rd_stb,
  input  logic                clr_stb,
  input  logic                suspend,
  output logic [SECTOR_W-1:0] sector_q,
  output logic                fail_flag,
  output logic                overrun,
  output logic                frozen
);

  logic rd_seen, clr_seen;
  logic is_auto, is_semi, unlock;

  assign is_auto = (mode == 2'b00);
  assign is_semi = (mode == 2'b01);
  assign unlock  = frozen && rd_seen && clr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q  <= '0;
      fail_flag <= 1'b0;
      frozen    <= 1'b0;
      overrun   <= 1'b0;
      rd_seen   <= 1'b0;
      clr_seen  <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (sw_rst) begin
        sector_q  <= '0;
        fail_flag <= 1'b0;
        frozen    <= 1'b0;
        rd_seen   <= 1'b0;
        clr_seen  <= 1'b0;
      end else if (is_auto) begin
        if (fail_stb) begin
          rd_seen   <= 1'b0;
          clr_seen  <= 1'b0;
          fail_flag <= 1'b1;
          if (frozen) begin
            overrun <= 1'b1;
          end else begin
            sector_q <= sector_in;
            frozen   <= 1'b1;
          end
        end else if (unlock) begin
          frozen   <= 1'b0;
          rd_seen  <= 1'b0;
          clr_seen <= 1'b0;
        end else begin
          if (rd_stb && frozen && !suspend) rd_seen <= 1'b1;
          if (clr_stb && fail_flag) begin
            fail_flag <= 1'b0;
            clr_seen  <= 1'b1;
          end
        end
      end else if (is_semi && done_stb) begin
        sector_q <= sector_in;
      end
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && is_auto && fail_stb && !frozen) |=>
      (sector_q == $past(sector_in) && fail_flag && frozen));

  assert_overrun_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && is_auto && fail_stb && frozen) |=>
      (overrun && fail_flag && frozen && $stable(sector_q)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && frozen && !(rd_seen && clr_seen)) |=> frozen);

  assert_overrun_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  assert_semi_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && is_semi && done_stb) |=> (sector_q == $past(sector_in)));

  assert_cpu_mode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && mode[1]) |=>
      ($stable(sector_q) && $stable(fail_flag) && $stable(frozen) && !overrun));

  assert_swrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (sector_q == '0 && !fail_flag && !frozen));

endmodule

// File: tb/fail_sector_capture_bench.sv
module fail_sector_capture_bench;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [SW-1:0] sector_in = '0;
  logic fail_stb = 1'b0, done_stb = 1'b0, rd_stb = 1'b0, clr_stb = 1'b0, suspend = 1'b0;
  logic [SW-1:0] sector_q;
  logic fail_flag, overrun, frozen;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fail_sector_capture #(.SECTOR_W(SW)) u_fail_sector_capture (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode(mode), .sector_in(sector_in),
    .fail_stb(fail_stb), .done_stb(done_stb), .rd_stb(rd_stb), .clr_stb(clr_stb),
    .suspend(suspend), .sector_q(sector_q), .fail_flag(fail_flag),
    .overrun(overrun), .frozen(frozen)
  );

  task automatic chk(string req, logic [SW-1:0] es, logic ef, logic eo, logic ez);
    checks++;
    if (sector_q !== es || fail_flag !== ef || overrun !== eo || frozen !== ez) begin
      failures++;
      $display("FAIL %s: got sector=%0d flag=%b ovr=%b frz=%b exp sector=%0d flag=%b ovr=%b frz=%b",
               req, sector_q, fail_flag, overrun, frozen, es, ef, eo, ez);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(logic f, logic d, logic r, logic c, logic [SW-1:0] s);
    fail_stb = f; done_stb = d; rd_stb = r; clr_stb = c; sector_in = s;
    step();
    fail_stb = 0; done_stb = 0; rd_stb = 0; clr_stb = 0;
  endtask

  task automatic do_swrst();
    sw_rst = 1; step(); sw_rst = 0;
  endtask

  task automatic t_reset();
    chk("R1", 0, 0, 0, 0);
  endtask

  task automatic t_capture_read_clear();
    mode = 2'b00;
    pulse(1, 0, 0, 0, 8'd5);
    chk("R2", 5, 1, 0, 1);
    pulse(0, 0, 1, 0, 8'd0);
    chk("R4 read only", 5, 1, 0, 1);
    pulse(0, 0, 0, 1, 8'd0);
    chk("R6 clear", 5, 0, 0, 1);
    step();
    chk("R4 release", 5, 0, 0, 0);
  endtask

  task automatic t_overrun_clear_read();
    pulse(1, 0, 0, 0, 8'd7);
    chk("R2 recapture", 7, 1, 0, 1);
    pulse(1, 0, 0, 0, 8'd9);
    chk("R3 overrun", 7, 1, 1, 1);
    step();
    chk("R3 single pulse", 7, 1, 0, 1);
    pulse(0, 0, 0, 1, 8'd0);
    pulse(0, 0, 1, 0, 8'd0);
    chk("R4 clear then read", 7, 0, 0, 1);
    step();
    chk("R4 release other order", 7, 0, 0, 0);
  endtask

  task automatic t_overrun_discards();
    pulse(1, 0, 0, 0, 8'd12);
    pulse(0, 0, 1, 0, 8'd0);
    pulse(1, 0, 0, 0, 8'd13);
    pulse(0, 0, 0, 1, 8'd0);
    step(); step();
    chk("R3 read discarded", 12, 0, 0, 1);
    pulse(0, 0, 1, 0, 8'd0);
    step();
    chk("R3 release after new read", 12, 0, 0, 0);
  endtask

  task automatic t_suspend();
    pulse(1, 0, 0, 0, 8'd20);
    suspend = 1;
    pulse(0, 0, 1, 0, 8'd0);
    suspend = 0;
    pulse(0, 0, 0, 1, 8'd0);
    step(); step();
    chk("R5 suspended read ignored", 20, 0, 0, 1);
    pulse(0, 0, 1, 0, 8'd0);
    chk("R5 not yet", 20, 0, 0, 1);
    step();
    chk("R5 release", 20, 0, 0, 0);
  endtask

  task automatic t_clear_vs_fail();
    pulse(1, 0, 0, 0, 8'd30);
    pulse(1, 0, 0, 1, 8'd31);
    chk("R6 fail wins frozen", 30, 1, 1, 1);
    do_swrst();
    pulse(1, 0, 0, 1, 8'd33);
    chk("R6 fail wins idle", 33, 1, 0, 1);
  endtask

  task automatic t_swrst();
    pulse(1, 0, 0, 0, 8'd44);
    do_swrst();
    chk("R9", 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 8'd45);
    sw_rst = 1; fail_stb = 1; sector_in = 8'd46;
    step();
    sw_rst = 0; fail_stb = 0;
    chk("R9 priority", 0, 0, 0, 0);
  endtask

  task automatic t_semi();
    mode = 2'b01;
    pulse(0, 1, 0, 0, 8'd3);
    chk("R7 load", 3, 0, 0, 0);
    pulse(1, 0, 1, 1, 8'd4);
    chk("R7 fail ignored", 3, 0, 0, 0);
    pulse(0, 1, 0, 0, 8'd11);
    chk("R7 reload", 11, 0, 0, 0);
  endtask

  task automatic t_cpu_mode();
    mode = 2'b00;
    pulse(1, 0, 0, 0, 8'd50);
    mode = 2'b10;
    pulse(1, 1, 1, 1, 8'd51);
    chk("R8 mode 10", 50, 1, 0, 1);
    mode = 2'b11;
    pulse(1, 1, 0, 1, 8'd52);
    chk("R8 mode 11", 50, 1, 0, 1);
  endtask

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_capture_read_clear();
    t_overrun_clear_read();
    t_overrun_discards();
    t_suspend();
    t_clear_vs_fail();
    t_swrst();
    t_semi();
    t_cpu_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule